// File: doc/BRIEF.md
# Card Presence Detect Debouncer

This block tells the rest of a smart-card subsystem whether a card sits in the slot. It samples one raw detect pin through a two-flop synchronizer and interprets it with a programmable polarity. It then produces a read-only inserted flag. Software configures the block through a single 8-bit control/status register. The flag can be qualified by an asymmetric debounce. Insertion must hold for a run of ticks from a 1 kHz strobe, while removal clears the flag at once.

A power-down input skips the debounce and keeps detection live. Whenever the inserted flag changes value, the block emits a one-cycle event pulse for an interrupt source. It also drives the pad pull-up and pull-down enables straight from register bits.

Top module: `card_detect_ctrl`

## Requirements
- R1: After reset the register reads 0x00. Bits 5 and 4 always read 0. Written bits 7,6,3,2,1 read back unchanged.
- R2: Bit 0 (inserted) is read-only, and a write of any value to it does not change it.
- R3: Bit 3 selects polarity. With bit 3 = 1, a pin level of 1 means present. With bit 3 = 0, a pin level of 0 means present.
- R4: With bit 7 (debounce) = 0 and power-down low, the inserted flag follows the qualified pin 3 clock edges after a pin change (two synchronizer stages, then the flag register).
- R5: With bit 7 = 1, the flag sets only after 64 consecutive tick strobes seen while the qualified input stays present. After 63 ticks it is still 0.
- R6: Loss of the qualified input clears the flag with no debounce delay, after the same 3-edge latency as R4.
- R7: Loss of the qualified input before the 64th tick restarts the debounce count from zero.
- R8: While power-down is high, the debounce is skipped and the flag follows the qualified input as in R4.
- R9: With bit 6 (detect enable) = 0, the flag is 0. Clearing bit 6 while the flag is set clears it.
- R10: Every change of the flag produces exactly one card_event pulse of one cycle, in the cycle the new flag value first reads back.
- R11: pullup_en_n equals bit 2 and pulldown_en equals bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data, bit 0 is the inserted flag |
| detect_pin | input | 1 | Raw asynchronous card detect pin |
| tick_1khz | input | 1 | One-cycle 1 kHz debounce strobe |
| pwr_down | input | 1 | Power-down, bypasses debounce |
| card_event | output | 1 | One-cycle pulse on any change of the inserted flag |
| pullup_en_n | output | 1 | Pad pull-up enable, active low |
| pulldown_en | output | 1 | Pad pull-down enable |

## Verification
A debounce counter that is left stale after an aborted insertion would show at the ports as a flag that rises early, before the 64th tick of a fresh run. The check counts exact ticks on both sides of the threshold. A flag register that mis-tracks the event logic would show within one cycle as a missing, doubled or stretched card_event around a readback change. A wrong synchronizer depth or a wrong polarity sense shows as the flag readback moving one edge off its expected cycle, or in the wrong direction.

// File: rtl/cdet_pkg.sv
package cdet_pkg;
  localparam int REG_W = 8;

  typedef struct packed {
    logic dbnc_en;
    logic det_en;
    logic pol_hi;
    logic pu_off;
    logic pd_on;
  } cdet_ctrl_t;

  function automatic logic [REG_W-1:0] pack_reg(cdet_ctrl_t c, logic ins);
    return {c.dbnc_en, c.det_en, 2'b00, c.pol_hi, c.pu_off, c.pd_on, ins};
  endfunction

  function automatic cdet_ctrl_t unpack_reg(logic [REG_W-1:0] d);
    cdet_ctrl_t c;
    c.dbnc_en = d[7];
    c.det_en  = d[6];
    c.pol_hi  = d[3];
    c.pu_off  = d[2];
    c.pd_on   = d[1];
    return c;
  endfunction
endpackage

// File: rtl/cdet_sync.sv
module cdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = async_in;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/cdet_debounce.sv
module cdet_debounce #(
  parameter int TICKS = 64,
  localparam int CW   = $clog2(TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          present,
  input  logic          dbnc_en,
  input  logic          bypass,
  input  logic          tick,
  output logic          flag,
  output logic          flag_evt,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);

  logic [CW-1:0] cnt_d;
  logic          flag_d;
  logic          evt_d;

  always_comb begin
    cnt_d  = cnt;
    flag_d = flag;
    if (!present) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (bypass || !dbnc_en) begin
      flag_d = 1'b1;
    end else if (tick && cnt != LIMIT) begin
      cnt_d = cnt + 1'b1;
      if (cnt_d == LIMIT) flag_d = 1'b1;
    end
    evt_d = flag_d ^ flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      flag     <= 1'b0;
      flag_evt <= 1'b0;
    end else begin
      cnt      <= cnt_d;
      flag     <= flag_d;
      flag_evt <= evt_d;
    end
  end
endmodule

// File: rtl/card_detect_ctrl.sv
module card_detect_ctrl #(
  parameter int DBNC_TICKS  = 64,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(DBNC_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wr_data,
  output logic [7:0] reg_rd_data,
  input  logic       detect_pin,
  input  logic       tick_1khz,
  input  logic       pwr_down,
  output logic       card_event,
  output logic       pullup_en_n,
  output logic       pulldown_en
);
  import cdet_pkg::*;

  cdet_ctrl_t ctrl_q, ctrl_d;
  logic       pin_sync;
  logic       present;
  logic       flag;
  logic [CW-1:0] cnt;

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_wr_en) ctrl_d = unpack_reg(reg_wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  cdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (detect_pin),
    .sync_out (pin_sync)
  );

  assign present = ctrl_q.det_en & ~(pin_sync ^ ctrl_q.pol_hi);

  cdet_debounce #(.TICKS(DBNC_TICKS)) u_dbnc (
    .clk      (clk),
    .rst_n    (rst_n),
    .present  (present),
    .dbnc_en  (ctrl_q.dbnc_en),
    .bypass   (pwr_down),
    .tick     (tick_1khz),
    .flag     (flag),
    .flag_evt (card_event),
    .cnt      (cnt)
  );

  assign reg_rd_data = pack_reg(ctrl_q, flag);
  assign pullup_en_n = ctrl_q.pu_off;
  assign pulldown_en = ctrl_q.pd_on;
endmodule

// File: rtl/card_detect_ctrl_chk.sv
module card_detect_ctrl_chk #(
  parameter int TICKS = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    reg_rd_data,
  input logic          card_event,
  input logic          tick_1khz,
  input logic          pwr_down,
  input logic          pullup_en_n,
  input logic          pulldown_en,
  input logic [CW-1:0] cnt
);
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[5:4] == 2'b00);                                               // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TICKS));                                                       // R5
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reg_rd_data[0]) && $past(reg_rd_data[7]) && !$past(pwr_down)) |-> $past(tick_1khz)); // R5
  AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_data[6] |=> !reg_rd_data[0]);                                     // R9
  AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[0] != $past(reg_rd_data[0])) |-> card_event);                // R10
  AST_EVT_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    card_event |-> (reg_rd_data[0] != $past(reg_rd_data[0])));                // R10
  AST_PAD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pullup_en_n == reg_rd_data[2]) && (pulldown_en == reg_rd_data[1]));      // R11
endmodule

bind card_detect_ctrl card_detect_ctrl_chk #(.TICKS(DBNC_TICKS), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rd_data (reg_rd_data),
  .card_event  (card_event),
  .tick_1khz   (tick_1khz),
  .pwr_down    (pwr_down),
  .pullup_en_n (pullup_en_n),
  .pulldown_en (pulldown_en),
  .cnt         (cnt)
);

// File: tb/tb_card_detect_ctrl.sv
module tb_card_detect_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic       detect_pin = 1'b0;
  logic       tick_1khz = 1'b0;
  logic       pwr_down = 1'b0;
  logic       card_event;
  logic       pullup_en_n;
  logic       pulldown_en;

  always #4 clk = ~clk;

  card_detect_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .detect_pin(detect_pin), .tick_1khz(tick_1khz),
    .pwr_down(pwr_down), .card_event(card_event), .pullup_en_n(pullup_en_n),
    .pulldown_en(pulldown_en)
  );

  typedef struct {
    string      tag;
    logic [9:0] mask;
    logic [9:0] exp;
    int         exp_evts;
  } item_t;

  item_t sb_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  int    evt_seen = 0;
  int    exp_evts = 0;
  bit    evt_prev = 1'b0;
  bit    done = 1'b0;

  // event counter, sampled away from the edge; stretched pulses break R10
  always @(posedge clk) begin
    #2;
    if (card_event) begin
      evt_seen++;
      if (evt_prev) begin
        n_tests++; n_fail++;
        $display("FAIL R10 event wider than one cycle: actual 2+ cycles expected 1");
      end
    end
    evt_prev = card_event;
  end

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      logic [9:0] act;
      wait (sb_q.size() > 0);
      it  = sb_q.pop_front();
      act = {pullup_en_n, pulldown_en, reg_rd_data};
      n_tests++;
      if ((act & it.mask) != (it.exp & it.mask)) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act & it.mask, it.exp & it.mask);
      end
      if (it.exp_evts >= 0) begin
        n_tests++;
        if (evt_seen != it.exp_evts) begin
          n_fail++;
          $display("FAIL %s events: actual %0d expected %0d", it.tag, evt_seen, it.exp_evts);
        end
      end
    end
  end

  task automatic push(string tag, logic [9:0] mask, logic [9:0] exp, bit with_evt);
    item_t it;
    it.tag = tag; it.mask = mask; it.exp = exp;
    it.exp_evts = with_evt ? exp_evts : -1;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic expect_ins(string tag, logic v);
    push(tag, 10'h001, {9'd0, v}, 1'b1);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1khz = 1'b1;
      @(negedge clk); tick_1khz = 1'b0;
    end
  endtask

  task automatic pin(logic v);
    @(negedge clk); detect_pin = v;
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    push("R1 reset value", 10'h3FF, 10'h000, 1'b1);

    // R3/R4 polarity high, no debounce
    wr(8'h48);
    pin(1'b1); cyc(2); expect_ins("R4 not yet after 2 edges", 1'b0);
    cyc(1); exp_evts++; expect_ins("R4 set after 3 edges pol=1", 1'b1);
    pin(1'b0); cyc(3); exp_evts++; expect_ins("R6 clear pol=1", 1'b0);

    // R3 polarity low
    wr(8'h40); cyc(3); exp_evts++; expect_ins("R3 pin 0 present pol=0", 1'b1);
    pin(1'b1); cyc(3); exp_evts++; expect_ins("R3 pin 1 absent pol=0", 1'b0);

    // R5 debounce threshold
    wr(8'hC8); pin(1'b1); cyc(4);
    expect_ins("R5 no ticks yet", 1'b0);
    ticks(63); expect_ins("R5 63 ticks", 1'b0);
    ticks(1); exp_evts++; expect_ins("R5 64 ticks", 1'b1);

    // R6 immediate removal while debounce on
    pin(1'b0); cyc(2); expect_ins("R6 before latency", 1'b1);
    cyc(1); exp_evts++; expect_ins("R6 immediate removal", 1'b0);

    // R7 restart
    pin(1'b1); cyc(4); ticks(40);
    pin(1'b0); cyc(4); pin(1'b1); cyc(4);
    ticks(63); expect_ins("R7 count restarted", 1'b0);
    ticks(1); exp_evts++; expect_ins("R7 64 after restart", 1'b1);

    // R2 bit 0 read-only: write 0 while set, write 1 while clear
    wr(8'hC8); cyc(1);
    push("R2 write 0 keeps flag", 10'h0FF, 10'h0C9, 1'b1);
    pin(1'b0); cyc(3); exp_evts++;
    wr(8'h49); cyc(1);
    push("R2 write 1 ignored", 10'h0FF, 10'h048, 1'b1);

    // R8 power-down bypass with debounce enabled
    wr(8'hC8); pwr_down = 1'b1;
    pin(1'b1); cyc(3); exp_evts++; expect_ins("R8 bypass no ticks", 1'b1);
    pin(1'b0); cyc(3); exp_evts++; expect_ins("R8 removal in power-down", 1'b0);
    pin(1'b1); cyc(3); exp_evts++; expect_ins("R8 re-insert", 1'b1);

    // R9 clear detect enable
    wr(8'h88); cyc(1); exp_evts++;
    expect_ins("R9 disable clears flag", 1'b0);
    pwr_down = 1'b0; cyc(3);
    expect_ins("R9 disabled stays absent", 1'b0);

    // R1/R11 unused bits and pads
    wr(8'h36); cyc(1);
    push("R11 pads and R1 unused bits", 10'h3FF, {1'b1, 1'b1, 8'h06}, 1'b1);
    wr(8'h00); cyc(1);
    push("R11 pads reset", 10'h3FF, 10'h000, 1'b1);

    cyc(2);
    wait (sb_q.size() == 0);
    #1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule